// File: doc/BRIEF.md
# Half-step SPI clock divider

This block makes the serial clock for an SPI host port from a single 125 MHz reference clock. The divide ratio is an integer from 1 to 7, or that integer plus one half. A low-frequency switch places a divide-by-8 prescale in front of the divisor. A half-step ratio has an odd number of reference half-cycles per output period. The block therefore works in half-cycle slots. Each reference cycle it registers a two-slot pair: bit 0 is the level for the first half of the cycle (clock high) and bit 1 is the level for the second half. A double-data-rate output cell at the pad turns each pair into the pin waveform.

The read phase and the write phase each have their own divisor code and half-step enable. A direction input picks one of the two sets. The divisor code, half-step enable, low-frequency switch and clock-invert setting are captured on the cycle the clock starts. They stay frozen until the clock is idle again. The clock runs while `run` is high. After `run` falls, the clock always completes its current output period before it returns to the idle level. The idle level equals the invert setting. Two strobes mark each rising and falling edge of the output so that the data shifter knows when to act.

Top module: `halfstep_sclk_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `sclk_ddr` is 2'b00 and both strobes are 0.
- R2: With the half-step enable clear and low-frequency mode off, code N gives a period of 2N half-cycle slots. The high phase comes first and lasts N slots.
- R3: With the half-step enable set and low-frequency mode off, code N gives a period of 2N+1 slots: N high slots followed by N+1 low slots. Code 2 is ratio 2.5 and code 3 is ratio 3.5.
- R4: Low-frequency mode multiplies the period by 8. The high phase is then exactly half the period.
- R5: `dir_wr` = 0 selects `rd_code`/`rd_half` and `dir_wr` = 1 selects `wr_code`/`wr_half`. The selection is made on the edge where the clock starts.
- R6: A divisor code of 0 behaves exactly like code 1.
- R7: While idle, both slots of `sclk_ddr` equal `clk_inv`, and no strobe is raised. While running, every slot is the non-inverted level XOR the captured `clk_inv`.
- R8: Changes to the configuration inputs while the clock runs have no effect on the running clock.
- R9: After `run` falls, the output completes whole periods only, with no runt pulse. The number of periods is ceil(2K/T), where K is the number of cycles `run` was high and T is the period in slots.
- R10: `rise_stb` is high in exactly those cycles where the output goes from 0 to 1, either between the previous pair's second slot and the current first slot, or inside the current pair. `fall_stb` marks 1-to-0 edges in the same way. Both strobes can be high in the same cycle.
- R11: The first pair after the edge that starts the clock begins with the first slot of the high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 125 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_code | input | CODE_W | Divisor code for the read phase |
| rd_half | input | 1 | Adds one half to the read ratio |
| wr_code | input | CODE_W | Divisor code for the write phase |
| wr_half | input | 1 | Adds one half to the write ratio |
| dir_wr | input | 1 | 1 selects the write settings, 0 the read settings |
| low_freq | input | 1 | Inserts the divide-by-PRESCALE stage |
| clk_inv | input | 1 | Inverts the output and sets the idle level |
| run | input | 1 | Requests the serial clock |
| sclk_ddr | output | 2 | Slot levels: bit 0 first half, bit 1 second half of the reference cycle |
| rise_stb | output | 1 | Output has a rising edge in this cycle |
| fall_stb | output | 1 | Output has a falling edge in this cycle |

## Verification
The bench builds the block with its defaults, CODE_W = 3 and PRESCALE = 8. These values reach every code from 0 to 7 and the longest period of 120 slots. Odd periods of 3, 5 and 7 slots make a period end in the middle of a reference cycle, which tests the cut second slot on stop. Even periods with 2K a multiple of T test the case where the clock stops with no final pair. Other bursts change every configuration input during a run and choose opposite read and write codes.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  // Upper bound on slots per period: prescale times (2*max_code + 1)
  function automatic int unsigned max_slots(int unsigned code_w, int unsigned pre);
    return pre * (2 * ((1 << code_w) - 1) + 1);
  endfunction
endpackage

// File: rtl/hsd_cfg_hold.sv
module hsd_cfg_hold #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned PRESCALE = 8,
  parameter int unsigned POS_W    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic [CODE_W-1:0] rd_code,
  input  logic              rd_half,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_half,
  input  logic              dir_wr,
  input  logic              low_freq,
  input  logic              clk_inv,
  output logic [POS_W-1:0]  period,
  output logic [POS_W-1:0]  high_len,
  output logic              inv
);
  localparam logic [POS_W-1:0] PRE_V = POS_W'(PRESCALE);

  logic [CODE_W-1:0] code_sel, code_eff;
  logic              half_sel;
  logic [POS_W-1:0]  base, fresh_per, per_q;
  logic              inv_q;

  always_comb begin
    code_sel  = dir_wr ? wr_code : rd_code;
    half_sel  = dir_wr ? wr_half : rd_half;
    code_eff  = (code_sel == '0) ? CODE_W'(1) : code_sel;
    base      = POS_W'({code_eff, 1'b0}) + POS_W'(half_sel);
    fresh_per = low_freq ? (base * PRE_V) : base;
  end

  // Captured settings track the inputs only while the clock is idle
  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= POS_W'(2);
      inv_q <= 1'b0;
    end else if (!busy) begin
      per_q <= fresh_per;
      inv_q <= clk_inv;
    end
  end

  always_comb begin
    period   = busy ? per_q : fresh_per;
    inv      = busy ? inv_q : clk_inv;
    high_len = period >> 1;
  end

  // R2
  period_min_chk: assert property (@(posedge clk) disable iff (rst)
    period >= POS_W'(2));
endmodule

// File: rtl/hsd_phase_ctr.sv
module hsd_phase_ctr #(
  parameter int unsigned POS_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [POS_W-1:0] period,
  input  logic [POS_W-1:0] high_len,
  output logic             busy,
  output logic             emit,
  output logic             lvl0,
  output logic             lvl1
);
  logic [POS_W-1:0] pos_q, pos_n, cur, sum1, sum2, nxt1, nxt2;
  logic             busy_q, busy_n, cut;

  always_comb begin
    cur  = busy_q ? pos_q : '0;
    sum1 = cur + POS_W'(1);
    sum2 = cur + POS_W'(2);
    nxt1 = (sum1 == period) ? '0 : sum1;
    nxt2 = (sum2 >= period) ? (sum2 - period) : sum2;
    emit   = 1'b0;
    cut    = 1'b0;
    busy_n = busy_q;
    pos_n  = pos_q;
    if (!busy_q) begin
      emit   = run;
      busy_n = run;
      pos_n  = run ? nxt2 : '0;
    end else if (run) begin
      emit  = 1'b1;
      pos_n = nxt2;
    end else if (pos_q == '0) begin
      busy_n = 1'b0;
    end else if (pos_q == period - POS_W'(2)) begin
      emit   = 1'b1;
      busy_n = 1'b0;
      pos_n  = '0;
    end else if (pos_q == period - POS_W'(1)) begin
      emit   = 1'b1;
      cut    = 1'b1;
      busy_n = 1'b0;
      pos_n  = '0;
    end else begin
      emit  = 1'b1;
      pos_n = nxt2;
    end
    lvl0 = cur < high_len;
    lvl1 = cut ? 1'b0 : (nxt1 < high_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      pos_q  <= pos_n;
      busy_q <= busy_n;
    end
  end

  assign busy = busy_q;

  // R2
  pos_in_period_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (pos_q < period));
  // R11
  start_pos_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> (pos_q == ((period == POS_W'(2)) ? '0 : POS_W'(2))));
endmodule

// File: rtl/hsd_out_stage.sv
module hsd_out_stage (
  input  logic       clk,
  input  logic       rst,
  input  logic       emit,
  input  logic       lvl0,
  input  logic       lvl1,
  input  logic       inv,
  output logic [1:0] pair,
  output logic       rise,
  output logic       fall
);
  logic [1:0] pair_q;
  logic       rise_q, fall_q, o0, o1;

  always_comb begin
    o0 = emit ? (lvl0 ^ inv) : inv;
    o1 = emit ? (lvl1 ^ inv) : inv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q <= 2'b00;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      pair_q <= {o1, o0};
      rise_q <= emit && ((!pair_q[1] && o0) || (!o0 && o1));
      fall_q <= emit && ((pair_q[1] && !o0) || (o0 && !o1));
    end
  end

  assign pair = pair_q;
  assign rise = rise_q;
  assign fall = fall_q;

  // R10
  rise_has_high_chk: assert property (@(posedge clk) disable iff (rst)
    rise_q |-> (pair_q != 2'b00));
  // R10
  fall_has_low_chk: assert property (@(posedge clk) disable iff (rst)
    fall_q |-> (pair_q != 2'b11));
endmodule

// File: rtl/halfstep_sclk_gen.sv
module halfstep_sclk_gen #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned PRESCALE = 8
) (
  input  logic              clk_ref,
  input  logic              rst,
  input  logic [CODE_W-1:0] rd_code,
  input  logic              rd_half,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_half,
  input  logic              dir_wr,
  input  logic              low_freq,
  input  logic              clk_inv,
  input  logic              run,
  output logic [1:0]        sclk_ddr,
  output logic              rise_stb,
  output logic              fall_stb
);
  localparam int unsigned MAX_T = hsd_pkg::max_slots(CODE_W, PRESCALE);
  localparam int unsigned POS_W = $clog2(MAX_T + 2);

  logic [POS_W-1:0] period, high_len;
  logic             inv, busy, emit, lvl0, lvl1;

  hsd_cfg_hold #(.CODE_W(CODE_W), .PRESCALE(PRESCALE), .POS_W(POS_W)) u_cfg (
    .clk(clk_ref), .rst(rst), .busy(busy),
    .rd_code(rd_code), .rd_half(rd_half), .wr_code(wr_code), .wr_half(wr_half),
    .dir_wr(dir_wr), .low_freq(low_freq), .clk_inv(clk_inv),
    .period(period), .high_len(high_len), .inv(inv)
  );

  hsd_phase_ctr #(.POS_W(POS_W)) u_ctr (
    .clk(clk_ref), .rst(rst), .run(run), .period(period), .high_len(high_len),
    .busy(busy), .emit(emit), .lvl0(lvl0), .lvl1(lvl1)
  );

  hsd_out_stage u_out (
    .clk(clk_ref), .rst(rst), .emit(emit), .lvl0(lvl0), .lvl1(lvl1), .inv(inv),
    .pair(sclk_ddr), .rise(rise_stb), .fall(fall_stb)
  );

  // R9
  stop_at_idle_chk: assert property (@(posedge clk_ref) disable iff (rst)
    $fell(busy) |-> (sclk_ddr[1] == $past(inv)));
  // R7
  idle_flat_chk: assert property (@(posedge clk_ref) disable iff (rst)
    (!busy && !$past(busy)) |-> ((sclk_ddr[0] == sclk_ddr[1]) && !rise_stb && !fall_stb));
endmodule

// File: tb/halfstep_sclk_gen_tb.sv
module halfstep_sclk_gen_tb;
  localparam int CODE_W = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic [CODE_W-1:0] rd_code = '0, wr_code = '0;
  logic rd_half = 0, wr_half = 0, dir_wr = 0, low_freq = 0, clk_inv = 0, run = 0;
  logic [1:0] sclk_ddr;
  logic rise_stb, fall_stb;

  halfstep_sclk_gen #(.CODE_W(CODE_W), .PRESCALE(8)) u_dut (
    .clk_ref(clk), .rst(rst), .rd_code(rd_code), .rd_half(rd_half),
    .wr_code(wr_code), .wr_half(wr_half), .dir_wr(dir_wr), .low_freq(low_freq),
    .clk_inv(clk_inv), .run(run), .sclk_ddr(sclk_ddr),
    .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  typedef struct packed { logic [1:0] pair; logic rise; logic fall; } item_t;
  item_t exp_q[$];
  string tag_q[$];
  int total = 0, bad = 0;

  // Monitor: one expected item per clock edge while the queue holds any
  initial forever begin
    @(posedge clk); #2;
    if (exp_q.size() > 0) begin
      item_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (sclk_ddr !== e.pair || rise_stb !== e.rise || fall_stb !== e.fall) begin
        bad++;
        $display("FAIL %s: got pair=%b rise=%b fall=%b, expected pair=%b rise=%b fall=%b",
                 t, sclk_ddr, rise_stb, fall_stb, e.pair, e.rise, e.fall);
      end
    end
  end

  function automatic bit slot_lvl(int i, int s_cnt, int t, bit inv);
    if (i < s_cnt) return ((i % t) < (t / 2)) ^ inv;
    return inv;
  endfunction

  // Driver: sets config, pushes the predicted pairs, then pulses run for k cycles
  task automatic burst(string tag, int rc, bit rh, int wc, bit wh, bit dw,
                       bit lf, bit inv, int k, bit scramble);
    int n, t, s_cnt, last_j;
    @(negedge clk);
    rd_code = CODE_W'(rc); rd_half = rh; wr_code = CODE_W'(wc); wr_half = wh;
    dir_wr = dw; low_freq = lf; clk_inv = inv; run = 0;
    @(negedge clk);
    n = dw ? wc : rc;
    if (n == 0) n = 1;
    t = (lf ? 8 : 1) * (2 * n + (dw ? int'(wh) : int'(rh)));
    s_cnt = ((2 * k + t - 1) / t) * t;
    last_j = (s_cnt + 1) / 2 + 1;
    for (int j = 0; j <= last_j; j++) begin
      item_t e;
      bit p, a, b;
      p = (j == 0) ? inv : slot_lvl(2 * j - 1, s_cnt, t, inv);
      a = slot_lvl(2 * j, s_cnt, t, inv);
      b = slot_lvl(2 * j + 1, s_cnt, t, inv);
      e.pair = {b, a};
      e.rise = (!p && a) || (!a && b);
      e.fall = (p && !a) || (a && !b);
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    run = 1;
    for (int c = 1; c <= k; c++) begin
      @(negedge clk);
      if (scramble && c == 1) begin
        rd_code = ~rd_code; wr_code = ~wr_code; rd_half = ~rd_half;
        wr_half = ~wr_half; dir_wr = ~dir_wr; low_freq = ~low_freq; clk_inv = ~clk_inv;
      end
    end
    run = 0;
    rd_code = CODE_W'(rc); rd_half = rh; wr_code = CODE_W'(wc); wr_half = wh;
    dir_wr = dw; low_freq = lf; clk_inv = inv;
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic idle_level(bit inv, int n);
    @(negedge clk);
    clk_inv = inv;
    for (int j = 0; j < n; j++) begin
      item_t e;
      e.pair = {inv, inv}; e.rise = 0; e.fall = 0;
      exp_q.push_back(e);
      tag_q.push_back("R7 idle level");
    end
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    total++;
    if (sclk_ddr !== 2'b00 || rise_stb !== 1'b0 || fall_stb !== 1'b0) begin
      bad++;
      $display("FAIL R1 in reset: got %b/%b/%b, expected 00/0/0", sclk_ddr, rise_stb, fall_stb);
    end
    rst = 0;
    @(negedge clk);
    total++;
    if (sclk_ddr !== 2'b00 || rise_stb !== 1'b0 || fall_stb !== 1'b0) begin
      bad++;
      $display("FAIL R1 after reset: got %b/%b/%b, expected 00/0/0", sclk_ddr, rise_stb, fall_stb);
    end
    burst("R2 code3 integer", 3, 0, 6, 0, 0, 0, 0, 5, 0);
    burst("R2 R9 code3 exact stop", 3, 0, 6, 0, 0, 0, 0, 3, 0);
    burst("R2 code1 ratio one", 1, 0, 0, 0, 0, 0, 0, 3, 0);
    burst("R2 code7", 7, 0, 1, 0, 0, 0, 0, 4, 0);
    burst("R3 code2 half", 2, 1, 5, 0, 0, 0, 0, 4, 0);
    burst("R3 R9 code3 half cut", 3, 1, 4, 0, 0, 0, 0, 3, 0);
    burst("R3 R10 code1 half", 1, 1, 4, 0, 0, 0, 0, 4, 0);
    burst("R6 code0 half", 0, 1, 4, 0, 0, 0, 0, 4, 0);
    burst("R6 code0 integer", 0, 0, 4, 0, 0, 0, 0, 2, 0);
    burst("R4 lowfreq code1 half", 1, 1, 3, 0, 0, 1, 0, 5, 0);
    burst("R4 lowfreq code2", 2, 0, 3, 0, 0, 1, 0, 2, 0);
    burst("R5 read selected", 2, 1, 5, 0, 0, 0, 0, 6, 0);
    burst("R5 write selected", 2, 1, 5, 0, 1, 0, 0, 6, 0);
    burst("R7 inverted half", 2, 1, 3, 0, 0, 0, 1, 5, 0);
    burst("R7 inverted cut", 3, 1, 3, 0, 0, 0, 1, 3, 0);
    burst("R8 config changes ignored", 3, 1, 4, 0, 0, 0, 0, 8, 1);
    burst("R8 R11 inverted changes ignored", 2, 0, 6, 1, 1, 0, 1, 7, 1);
    idle_level(1, 3);
    idle_level(0, 3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule